// File: doc/BRIEF.md
# Flash Controller Guarded Configuration and Interrupt Registers

This block is the register unit of a flash controller. It keeps the interface configuration word and the timing word behind a key: software first writes a fixed 16-bit key to a lock register, and only the next write to one of the two guarded registers is accepted. After that write the guard closes again by itself, so each guarded write needs its own key write.

The block also collects six event lines from the controller into sticky interrupt status bits. Each bit is set by the rising edge of its line and cleared by reading the status register. A mask register selects which latched bits drive the interrupt line, which is active-high and level-sensitive. A separate raw status register shows the current levels of the lines plus the corrected-error count, and reading it does not clear anything.

Register access uses a simple single-cycle port. Read data is registered and appears one cycle after the read strobe. Word addresses: 0 lock, 1 interface config, 2 timing, 3 interrupt mask, 4 interrupt status, 5 raw status. All other addresses read zero.

Top module: `flashctl_guard_regs`

## Requirements
- R1: After reset every register reads zero, `irq_out` is low, both configuration outputs are zero and the guard is closed.
- R2: A write of 0xA25E in bits 15:0 to the lock register (address 0) opens the guard. The next write to interface config (address 1) or timing (address 2) is then stored.
- R3: A guarded write closes the guard again, so a second guarded write without a new key write leaves the register unchanged.
- R4: A guarded write while the guard is closed is ignored and the register keeps its value.
- R5: A lock-register write with any value other than the key leaves the guard closed, and also closes a guard that was open.
- R6: Interface config holds bits 3:0 (bit0 16-bit bus, bit1 long 5-byte address, bit2 large block, bit3 write protect) and drives them on `cfg_iface`. Bits above 3 read zero.
- R7: Timing holds bits 26:0, drives them on `cfg_timing`, and reads zero above bit 26.
- R8: Each interrupt status bit is set by a rising edge of its event line, whatever the mask value. The bit map of `evt_in`, mask and status is: bit0 write-protect fault, bit1 ECC ready, bit2 decode error, bit3 decode failure, bit4 controller ready, bit5 NAND ready. A line held high sets its bit only once.
- R9: A read of interrupt status (address 4) returns the latched bits and clears all of them.
- R10: A rising edge in the same cycle as a status read is kept: it is not in that read, but it is set afterwards.
- R11: `irq_out` is high while any status bit is set whose mask bit (address 3, bits 5:0) is set.
- R12: Raw status (address 5) reads bit0 NAND ready, bit1 controller ready, bit2 ECC ready, bit3 errors detected (decode error line), bits 5:4 `err_cnt`, bit6 decoder failure. It shows the current input levels and reading it clears nothing.
- R13: The mask register is written without a key, stores bits 5:0, and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| evt_in | input | 6 | Event lines, bit map as in R8 |
| err_cnt | input | 2 | Corrected-error count minus one, shown in raw status |
| cfg_iface | output | 4 | Stored interface config |
| cfg_timing | output | 27 | Stored timing word |
| irq_out | output | 1 | Level interrupt, active high |

## Verification
Writes take effect at the clock edge where the strobe is sampled. Read data, a status clear and a status set from an event edge all land at that same edge, so `reg_rdata`, `irq_out` and the configuration outputs can be observed one edge after the stimulus. The bench drives every strobe and event on a falling edge for exactly one cycle and samples on the next falling edge, which is the first point where the result is valid. Each status check follows one event pulse, and a second read then confirms the clear, so a late or a lingering bit shows up as a mismatch.

// File: rtl/flashctl_guard_pkg.sv
// Package: shared address map and bit positions for the guarded
// configuration and interrupt register unit.
// Assumes word addressing on a 4-bit register address.
package flashctl_guard_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int EVT_N   = 6;
    localparam int IFACE_W = 4;
    localparam int TIME_W  = 27;
    localparam int KEY_W   = 16;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA25E;

    typedef enum logic [ADDR_W-1:0] {
        RA_LOCK  = 4'd0,
        RA_IFACE = 4'd1,
        RA_TIME  = 4'd2,
        RA_MASK  = 4'd3,
        RA_STAT  = 4'd4,
        RA_RAW   = 4'd5
    } reg_addr_e;

    // event / mask / status bit positions
    localparam int EV_WPFAULT = 0;
    localparam int EV_ECCRDY  = 1;
    localparam int EV_DECERR  = 2;
    localparam int EV_DECFAIL = 3;
    localparam int EV_CTLRDY  = 4;
    localparam int EV_NANDRDY = 5;

    localparam int RAW_W = 7;
endpackage

// File: rtl/flashctl_key_gate.sv
// Module: single-shot key gate. A lock-register write carrying the key
// opens the gate. Any guarded write or any other lock-register value
// closes it again.
// Assumes the lock write and the guarded write never coincide, because
// they decode from one address.
module flashctl_key_gate #(
    parameter int KEY_W = 16,
    parameter logic [KEY_W-1:0] KEY = 16'hA25E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic [KEY_W-1:0] lock_data,
    input  logic             guarded_wr,
    output logic             gate_open
);
    // Tracks whether one guarded write is currently permitted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_open <= 1'b0;
        else if (lock_wr)
            gate_open <= (lock_data == KEY);
        else if (guarded_wr)
            gate_open <= 1'b0;
    end

    // R3
    relock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guarded_wr && !lock_wr) |=> !gate_open);
    // R5
    wrong_key_stays_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && lock_data != KEY) |=> !gate_open);
endmodule

// File: rtl/flashctl_guarded_reg.sv
// Module: storage register that accepts a write only while the key
// gate is open. The same register works as a plain one when the gate
// input is tied high.
// Assumes the write data is already narrowed to W bits.
module flashctl_guarded_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         gate_open,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Stores new data only on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en && gate_open)
            q <= wdata;
    end

    // R4
    locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !gate_open) |=> $stable(q));
endmodule

// File: rtl/flashctl_irq_unit.sv
// Module: sticky interrupt status with per-line rising-edge capture,
// clear on status read, and a masked level output.
// Assumes event lines are synchronous to clk. A rise in the clear
// cycle survives the clear.
module flashctl_irq_unit #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    input  logic         clr,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] evt_d;
    logic [N-1:0] rise;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Remembers last cycle's level of line i.
        always_ff @(posedge clk) begin
            if (!rst_n) evt_d[i] <= 1'b0;
            else        evt_d[i] <= evt[i];
        end

        // Flags a low-to-high change on line i.
        always_comb rise[i] = evt[i] & ~evt_d[i];

        // Sets on a rise, clears on a status read, otherwise holds.
        always_ff @(posedge clk) begin
            if (!rst_n)       status[i] <= 1'b0;
            else if (rise[i]) status[i] <= 1'b1;
            else if (clr)     status[i] <= 1'b0;
        end

        // R8
        rise_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> status[i]);
    end

    // Combines enabled status bits into the level interrupt.
    always_comb irq = |(status & mask);

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rise == '0) |=> (status == '0));
    // R8
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status)));
    // R10
    rise_during_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == $past(rise)));
endmodule

// File: rtl/flashctl_guard_regs.sv
// Module: top of the guarded configuration and interrupt register unit.
// It decodes the register port, holds the key gate, both guarded
// registers, the interrupt mask and the status unit, and returns
// read data one cycle after the strobe.
// Assumes at most one of reg_wr / reg_rd per cycle.
module flashctl_guard_regs
    import flashctl_guard_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NE = EVT_N,
    parameter int IW = IFACE_W,
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NE-1:0] evt_in,
    input  logic [1:0]    err_cnt,
    output logic [IW-1:0] cfg_iface,
    output logic [TW-1:0] cfg_timing,
    output logic          irq_out
);
    localparam int RW = RAW_W;

    logic wr_lock, wr_iface, wr_time, wr_mask, rd_stat;
    logic gate_open;
    logic [NE-1:0] mask_q, stat_q;
    logic [RW-1:0] raw_word;
    logic [DW-1:0] rd_mux;
    logic          unused_wbits;

    // Decodes write and read strobes per register.
    always_comb begin
        wr_lock  = reg_wr && (reg_addr == RA_LOCK);
        wr_iface = reg_wr && (reg_addr == RA_IFACE);
        wr_time  = reg_wr && (reg_addr == RA_TIME);
        wr_mask  = reg_wr && (reg_addr == RA_MASK);
        rd_stat  = reg_rd && (reg_addr == RA_STAT);
    end

    assign unused_wbits = ^reg_wdata[DW-1:TW];

    flashctl_key_gate #(.KEY_W(KEY_W), .KEY(UNLOCK_KEY)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_wr    (wr_lock),
        .lock_data  (reg_wdata[KEY_W-1:0]),
        .guarded_wr (wr_iface || wr_time),
        .gate_open  (gate_open)
    );

    flashctl_guarded_reg #(.W(IW)) u_iface (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_iface),
        .gate_open (gate_open),
        .wdata     (reg_wdata[IW-1:0]),
        .q         (cfg_iface)
    );

    flashctl_guarded_reg #(.W(TW)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_time),
        .gate_open (gate_open),
        .wdata     (reg_wdata[TW-1:0]),
        .q         (cfg_timing)
    );

    flashctl_guarded_reg #(.W(NE)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_mask),
        .gate_open (1'b1),
        .wdata     (reg_wdata[NE-1:0]),
        .q         (mask_q)
    );

    flashctl_irq_unit #(.N(NE)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_in),
        .mask   (mask_q),
        .clr    (rd_stat),
        .status (stat_q),
        .irq    (irq_out)
    );

    // Assembles the live raw status word from line levels and count.
    always_comb begin
        raw_word      = '0;
        raw_word[0]   = evt_in[EV_NANDRDY];
        raw_word[1]   = evt_in[EV_CTLRDY];
        raw_word[2]   = evt_in[EV_ECCRDY];
        raw_word[3]   = evt_in[EV_DECERR];
        raw_word[5:4] = err_cnt;
        raw_word[6]   = evt_in[EV_DECFAIL];
    end

    // Selects the word for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            RA_IFACE: rd_mux[IW-1:0] = cfg_iface;
            RA_TIME:  rd_mux[TW-1:0] = cfg_timing;
            RA_MASK:  rd_mux[NE-1:0] = mask_q;
            RA_STAT:  rd_mux[NE-1:0] = stat_q;
            RA_RAW:   rd_mux[RW-1:0] = raw_word;
            default:  rd_mux = '0;
        endcase
    end

    // Registers read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R11
    irq_drops_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && $past(evt_in) == evt_in) |=> !irq_out);
    // R2
    key_then_write_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_iface && gate_open) |=> (cfg_iface == $past(reg_wdata[IW-1:0])));
endmodule

// File: tb/flashctl_guard_regs_test.sv
module flashctl_guard_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  evt_in = '0;
    logic [1:0]  err_cnt = '0;
    logic [3:0]  cfg_iface;
    logic [26:0] cfg_timing;
    logic        irq_out;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    flashctl_guard_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .err_cnt(err_cnt), .cfg_iface(cfg_iface),
        .cfg_timing(cfg_timing), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic pulse(input int b);
        @(negedge clk); evt_in[b] = 1'b1;
        @(negedge clk); evt_in[b] = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] exp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[3:0], d); check("R1 reset readback", d, 32'h0);
        end
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        check("R1 cfg outputs", {1'b0, cfg_iface, cfg_timing}, 32'h0);
        wr(4'd1, 32'hF);
        rd(4'd1, d); check("R1 guard closed after reset", d, 32'h0);

        // R2 R3 R6 sweep over all interface config values
        for (int v = 0; v < 16; v++) begin
            wr(4'd0, 32'h0000_A25E);
            wr(4'd1, 32'hFFFF_FFF0 | v);
            rd(4'd1, d); check("R2 R6 iface stored", d, v);
            check("R6 cfg_iface", {28'b0, cfg_iface}, v);
            wr(4'd1, ~v);
            rd(4'd1, d); check("R3 second write ignored", d, v);
        end

        // R4 R7 timing
        wr(4'd2, 32'h0555_5555);
        rd(4'd2, d); check("R4 locked timing write", d, 32'h0);
        wr(4'd0, 32'h0000_A25E);
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d); check("R7 timing width", d, 32'h07FF_FFFF);
        check("R7 cfg_timing", {5'b0, cfg_timing}, 32'h07FF_FFFF);
        wr(4'd2, 32'h0);
        rd(4'd2, d); check("R4 timing kept", d, 32'h07FF_FFFF);
        wr(4'd0, 32'h0000_A25E);
        wr(4'd2, 32'h0123_4567);
        rd(4'd2, d); check("R2 timing via key", d, 32'h0123_4567);

        // R5 wrong keys
        wr(4'd0, 32'h0000_A25F);
        wr(4'd1, 32'h5);
        rd(4'd1, d); check("R5 wrong key", d, 32'hF);
        wr(4'd0, 32'h0000_A25E);
        wr(4'd0, 32'h0000_1234);
        wr(4'd1, 32'h5);
        rd(4'd1, d); check("R5 open gate closed by other value", d, 32'hF);

        // R13 mask sweep
        for (int m = 0; m < 64; m++) begin
            wr(4'd3, 32'hFFFF_FFC0 | m);
            rd(4'd3, d); check("R13 mask", d, m);
        end

        // R8 R9 R11 sweep: every mask against every line
        for (int m = 0; m < 64; m++) begin
            wr(4'd3, m);
            for (int b = 0; b < 6; b++) begin
                pulse(b);
                exp = (m >> b) & 1;
                check("R11 irq vs mask", {31'b0, irq_out}, exp);
                rd(4'd4, d); check("R8 R9 status bit", d, 32'h1 << b);
                check("R11 irq after read", {31'b0, irq_out}, 32'h0);
                rd(4'd4, d); check("R9 cleared", d, 32'h0);
            end
        end

        // R8 held line sets once; multiple bits accumulate
        wr(4'd3, 32'h3F);
        @(negedge clk); evt_in = 6'b100001;
        @(negedge clk);
        rd(4'd4, d); check("R8 two lines", d, 32'h21);
        rd(4'd4, d); check("R8 held line no re-set", d, 32'h0);
        check("R8 held no irq", {31'b0, irq_out}, 32'h0);
        @(negedge clk); evt_in = '0;

        // R10 rise during status read
        for (int b = 0; b < 6; b++) begin
            @(negedge clk); reg_rd = 1'b1; reg_addr = 4'd4; evt_in[b] = 1'b1;
            @(negedge clk); reg_rd = 1'b0; evt_in[b] = 1'b0; d = reg_rdata;
            check("R10 not in same read", d, 32'h0);
            check("R10 irq stays", {31'b0, irq_out}, 32'h1);
            rd(4'd4, d); check("R10 kept", d, 32'h1 << b);
        end

        // R12 raw status sweep
        for (int p = 0; p < 64; p++) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk); evt_in = p[5:0]; err_cnt = c[1:0];
                exp = 0;
                exp[0] = p[5]; exp[1] = p[4]; exp[2] = p[1];
                exp[3] = p[2]; exp[5:4] = c[1:0]; exp[6] = p[3];
                rd(4'd5, d); check("R12 raw", d, exp);
                rd(4'd5, d); check("R12 raw not cleared", d, exp);
            end
            @(negedge clk); evt_in = '0;
            rd(4'd4, d); check("R12 status untouched by raw read", d, p);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule